// File: doc/BRIEF.md
# Manchester Sync Lock Monitor

This monitor watches the sync bit that a Manchester receiver extracts once per frame and reports whether the stream is frame-locked. Upstream logic presents a one-cycle frame strobe together with the recovered sync bit. The monitor has no knowledge of bit recovery or payload. A valid stream flips its sync bit on every frame.

While unlocked, the monitor waits until one frame's sync bit is the inverse of the bit in the frame before it, and then asserts the lock flag. From that point it predicts the next sync value by inverting its prediction on every frame. A frame that does not match the prediction counts as a sync error.

Errors are judged inside an observation window of `WIN_FRAMES` frames. The window opens only when an error occurs, and it counts the error frame as frame 1. If `ERR_LIMIT` errors fall inside one window, lock is lost and acquisition restarts from nothing. If the window runs out first, the monitor goes idle until the next error, which opens a fresh window.

Top module: `sync_lock_mon`

## Requirements
- R1: After an asynchronous reset (`rst_ni` low), `locked_o` is 0, and acquisition starts with no frame history.
- R2: While unlocked, `locked_o` rises in the cycle after a strobed frame whose sync bit differs from the sync bit of the previous strobed frame. The first frame after reset or loss never locks. Two equal consecutive bits never lock.
- R3: When lock is acquired, the expected sync value for the next frame is the inverse of the bit that completed acquisition. After that, the expected value inverts on every strobed frame, whether or not that frame was an error.
- R4: While locked, frames that match the expected value never clear `locked_o`. Fewer than `ERR_LIMIT` (3) errors within one window also never clear it.
- R5: The window opens at an error frame and spans `WIN_FRAMES` (10) strobed frames, counting the opening frame. When the third error falls on any frame of that span, including frame 10, `locked_o` falls in the cycle after that frame's strobe.
- R6: If a window closes with fewer than 3 errors, error counting stays idle. The next error opens a new window with a count of one. For example, errors on window frames 1, 3 and 11 do not drop lock.
- R7: `locked_o` changes only in the cycle after a strobed frame. Cycles without a strobe have no effect, whatever `sync_bit_i` does. The window counts frames, not clock cycles.
- R8: After loss of lock, acquisition restarts with no history and the error window cleared. The frame that caused the loss is not used for reacquisition, so two further alternating frames are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | One-cycle strobe marking a received frame |
| sync_bit_i | input | 1 | Sync bit of the strobed frame |
| locked_o | output | 1 | 1 while the stream is frame-synchronized |

## Verification
The main sequence starts with repeated and then alternating bits, which separates a monitor that locks on any frame from one that needs a true alternation. Two error triples are then applied. The first is spread so that its third error lands one frame past the window, and the second lands exactly on the window's tenth frame, so an off-by-one in the window length shows up in one direction or the other. Directed runs follow. They toggle the sync bit with no strobe, spread the strobes over many idle cycles to confirm that the window counts frames and not cycles, and reset the monitor while it is locked.

// File: rtl/smlm_pkg.sv
package smlm_pkg;
  typedef enum logic {
    MON_ACQ  = 1'b0,
    MON_LOCK = 1'b1
  } mon_state_e;
endpackage

// File: rtl/smlm_acq.sv
// Acquisition: counts consecutive alternating frames while unlocked.
module smlm_acq #(
  parameter int ACQ_ALTS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic frame_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int ACW = $clog2(ACQ_ALTS + 1);

  logic           seen_q;
  logic           last_q;
  logic [ACW-1:0] alt_q;
  logic           alt_w;

  assign alt_w = seen_q && (bit_i != last_q);
  assign hit_o = en_i && frame_i && alt_w && (alt_q == ACW'(ACQ_ALTS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= 1'b0;
      alt_q  <= '0;
    end else if (!en_i || hit_o) begin
      seen_q <= 1'b0;
      last_q <= 1'b0;
      alt_q  <= '0;
    end else if (frame_i) begin
      seen_q <= 1'b1;
      last_q <= bit_i;
      alt_q  <= alt_w ? alt_q + ACW'(1) : '0;
    end
  end
endmodule

// File: rtl/smlm_phase.sv
// Expected-sync tracker: seeded at lock, inverted every locked frame.
module smlm_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seed_i,
  input  logic frame_i,
  input  logic locked_i,
  input  logic bit_i,
  output logic exp_o,
  output logic err_o
);
  logic exp_q;

  assign exp_o = exp_q;
  assign err_o = locked_i && frame_i && (bit_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= 1'b0;
    end else if (seed_i) begin
      exp_q <= ~bit_i;
    end else if (locked_i && frame_i) begin
      exp_q <= ~exp_q;
    end
  end
endmodule

// File: rtl/smlm_err_win.sv
// Error window: opens on an error, spans WIN_FRAMES frames, fires at ERR_LIMIT.
module smlm_err_win #(
  parameter int WIN_FRAMES = 10,
  parameter int ERR_LIMIT  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic frame_i,
  input  logic err_i,
  output logic drop_o
);
  localparam int WCW = $clog2(WIN_FRAMES + 1);
  localparam int ECW = $clog2(ERR_LIMIT + 1);

  logic           act_q;
  logic [WCW-1:0] win_q;
  logic [ECW-1:0] err_q;
  logic           at_limit_w;
  logic           win_end_w;

  assign at_limit_w = (err_q == ECW'(ERR_LIMIT - 1));
  assign win_end_w  = (win_q == WCW'(WIN_FRAMES - 1));
  assign drop_o     = en_i && frame_i && err_i && act_q && at_limit_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      win_q <= '0;
      err_q <= '0;
    end else if (!en_i || drop_o) begin
      act_q <= 1'b0;
      win_q <= '0;
      err_q <= '0;
    end else if (frame_i) begin
      if (!act_q) begin
        if (err_i) begin
          act_q <= 1'b1;
          win_q <= WCW'(1);
          err_q <= ECW'(1);
        end
      end else if (win_end_w) begin
        // last frame of window, limit not reached: go idle
        act_q <= 1'b0;
        win_q <= '0;
        err_q <= '0;
      end else begin
        win_q <= win_q + WCW'(1);
        if (err_i) err_q <= err_q + ECW'(1);
      end
    end
  end
endmodule

// File: rtl/sync_lock_mon.sv
module sync_lock_mon #(
  parameter int ACQ_ALTS   = 1,
  parameter int WIN_FRAMES = 10,
  parameter int ERR_LIMIT  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_vld_i,
  input  logic sync_bit_i,
  output logic locked_o
);
  import smlm_pkg::*;

  mon_state_e st_q;
  logic       lock_w;
  logic       hit_w;
  logic       err_w;
  logic       drop_w;
  logic       exp_w;

  assign lock_w   = (st_q == MON_LOCK);
  assign locked_o = lock_w;

  smlm_acq #(.ACQ_ALTS(ACQ_ALTS)) u_acq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (!lock_w),
    .frame_i (frame_vld_i),
    .bit_i   (sync_bit_i),
    .hit_o   (hit_w)
  );

  smlm_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .seed_i   (hit_w),
    .frame_i  (frame_vld_i),
    .locked_i (lock_w),
    .bit_i    (sync_bit_i),
    .exp_o    (exp_w),
    .err_o    (err_w)
  );

  smlm_err_win #(.WIN_FRAMES(WIN_FRAMES), .ERR_LIMIT(ERR_LIMIT)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (lock_w),
    .frame_i (frame_vld_i),
    .err_i   (err_w),
    .drop_o  (drop_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= MON_ACQ;
    end else begin
      unique case (st_q)
        MON_ACQ:  if (hit_w)  st_q <= MON_LOCK;
        MON_LOCK: if (drop_w) st_q <= MON_ACQ;
        default:              st_q <= MON_ACQ;
      endcase
    end
  end
endmodule

// File: rtl/smlm_chk.sv
module smlm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_vld_i,
  input logic sync_bit_i,
  input logic locked_o,
  input logic exp_i
);
  // R7: no strobe, no change
  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> $stable(locked_o));

  // R2: lock rises only after a strobe
  p_rise_on_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(frame_vld_i));

  // R4: matching frame keeps lock
  p_match_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && frame_vld_i && (sync_bit_i == exp_i)) |=> locked_o);

  // R3: prediction inverts on every locked frame
  p_exp_flip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && frame_vld_i) |=> (!locked_o || (exp_i != $past(exp_i))));

  // R5: loss only after an erroneous frame
  p_fall_on_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(frame_vld_i && (sync_bit_i != exp_i)));

  // R3: prediction steady without a strobe while locked
  p_exp_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !frame_vld_i) |=> $stable(exp_i));
endmodule

bind sync_lock_mon smlm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_vld_i (frame_vld_i),
  .sync_bit_i  (sync_bit_i),
  .locked_o    (locked_o),
  .exp_i       (exp_w)
);

// File: tb/sync_lock_mon_test.sv
`timescale 1ns/1ps
module sync_lock_mon_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_vld = 1'b0;
  logic sync_bit = 1'b0;
  logic locked;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  sync_lock_mon uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .frame_vld_i (frame_vld),
    .sync_bit_i  (sync_bit),
    .locked_o    (locked)
  );

  // {sync bit, expected lock after frame}
  localparam int NV = 31;
  localparam logic [1:0] VEC [0:NV-1] = '{
    2'b00, 2'b00, 2'b11, 2'b01, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b01,
    2'b11, 2'b01, 2'b11, 2'b01, 2'b11, 2'b11, 2'b01, 2'b10, 2'b10, 2'b01,
    2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b01, 2'b11, 2'b01, 2'b11, 2'b01,
    2'b00
  };

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (locked !== exp) begin
      n_fail++;
      $display("FAIL %s: locked_o=%b expected %b at %0t", req, locked, exp, $time);
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk);
    frame_vld = 1'b1;
    sync_bit  = b;
    @(negedge clk);
    frame_vld = 1'b0;
  endtask

  task automatic idle(input int n, input bit wiggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wiggle) sync_bit = ~sync_bit;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    idle(3, 1'b0);
    check(1'b0, "R1 reset");
    rst_n = 1'b1;
    idle(2, 1'b0);
    check(1'b0, "R1 after release");

    // Table: R2 acquisition, R3 prediction, R4 hold, R6 re-arm, R5 drop, R8 relock
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][1]);
      check(VEC[i][0], $sformatf("R2/R3/R4/R5/R6/R8 vector %0d", i));
    end

    // R7: no strobe, bit toggling, unlocked stays unlocked
    idle(6, 1'b1);
    check(1'b0, "R7 idle unlocked");

    // R8: the dropping frame (bit 0) is not history; one further frame cannot lock
    send(1'b1);
    check(1'b0, "R8 first frame after loss");
    send(1'b0);
    check(1'b1, "R2 relock");  // expected next = 1

    // R7: toggling bit with no strobe keeps lock
    idle(8, 1'b1);
    check(1'b1, "R7 idle locked");

    // R7: window counts frames; errors spread over long idle gaps
    send(1'b0);            // exp 1: error, window frame 1
    idle(30, 1'b0);
    send(1'b0);            // exp 0: ok, frame 2
    idle(30, 1'b0);
    send(1'b0);            // exp 1: error, frame 3
    check(1'b1, "R4 two errors keep lock");
    idle(30, 1'b0);
    send(1'b1);            // exp 0: error, frame 4 -> third
    check(1'b0, "R5 R7 third error over idle gaps");

    // R1: reset while locked
    send(1'b0);
    send(1'b1);
    check(1'b1, "R2 lock before reset");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 reset while locked");
    rst_n = 1'b1;
    send(1'b0);
    check(1'b0, "R1 no history after reset");

    finish_run();
  end
endmodule